// File: doc/BRIEF.md
# Vsync-Latched Window Configuration Shadow Bank

This block keeps two copies of the configuration for each overlay window of a display pipeline. Software writes the staged copy through a simple register port. The display logic sees only the active copy, and that copy changes only on the vsync pulse, at the same point where the frame fetch starts. An update request bit arms a transfer. Each window also has a protect bit. While a window's protect bit is set, its staged values stay pending and are held back. Software can therefore rewrite several fields of a window and have them take effect together in one frame.

Per window, the block holds an enable bit, a buffer base address and a rectangle given as top-left and bottom-right corners. A global display-on bit is held the same way, but it has no protect bit. The normal read port returns staged values. A second read port, driven by the same address, returns active values, so the moment of transfer can be observed from outside.

Top module: `shadow_bank`

## Requirements
- R1: After reset, every staged field, every active field, every protect bit and every pending flag is zero.
- R2: A write changes only the staged copy. It can be read back on `rd_data` after the write edge, and no active output changes on a cycle without vsync.
- R3: Writing address 0 with bit 1 set arms every window and the global field. Bit 0 of that write is the staged display-on value. At the next vsync, each unprotected window and the display-on bit copy their staged values to the active set, visible after that edge.
- R4: A vsync with nothing pending leaves all active values unchanged, even if staged values differ.
- R5: The protect register at address 1 holds one bit per window (bit w for window w). At vsync, a protected window's active values are left unchanged and the window stays pending, while other windows still transfer.
- R6: Clearing a pending window's protect bit lets it transfer at the next vsync, with no new update request.
- R7: Bit 1 of a read of address 0 is 1 while any window or the global field is pending, and it returns to 0 once all have transferred.
- R8: Clearing a window's staged enable bit keeps `act_win_en` at 1 until the vsync that commits it.
- R9: Window w occupies addresses 8+8w to 8+8w+3: enable in bit 0, base address, top-left corner, then bottom-right corner. Each corner holds x in bits 11:0 and y in bits 27:16. The protect register reads back its written value at once, because it is not shadowed.
- R10: An update request written in the same cycle as a vsync is not applied at that vsync. It is applied at the following one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync | input | 1 | One-cycle frame boundary pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Read address for both read ports |
| rd_data | output | 32 | Staged-copy read data (combinational) |
| act_rd_data | output | 32 | Active-copy read data (combinational) |
| act_disp_on | output | 1 | Active global display-on bit |
| act_win_en | output | NWIN | Active window enables |
| act_win_base | output | NWIN*BASE_W | Active base addresses, window 0 in the low slice |
| act_win_tl | output | NWIN*2*COORD_W | Active top-left corners, {y,x} per window |
| act_win_br | output | NWIN*2*COORD_W | Active bottom-right corners, {y,x} per window |

## Verification
The assertions assume that vsync is a single-cycle pulse that is synchronous to `clk`. They also assume that the register port is used one write per cycle. The stimulus respects both: it raises vsync for exactly one clock and issues writes one at a time. It also makes a write and a vsync coincide on purpose, to cover the ordering in R10. With an unchanged arm input, the pending and commit relations are checked against the active outputs one cycle later.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;
  localparam int ADDR_W     = 6;
  localparam int DATA_W     = 32;
  localparam int WIN_BASE   = 8;
  localparam int WIN_STRIDE = 8;
  localparam int Y_LSB      = 16;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] PROT_A = ADDR_W'(1);

  typedef enum logic [1:0] {
    F_ENA  = 2'd0,
    F_BASE = 2'd1,
    F_TL   = 2'd2,
    F_BR   = 2'd3
  } win_field_e;

  function automatic logic [ADDR_W-1:0] win_addr(input int w, input win_field_e f);
    return ADDR_W'(WIN_BASE + w * WIN_STRIDE + int'(f));
  endfunction
endpackage

// File: rtl/shadow_glob_slot.sv
module shadow_glob_slot
  import shadow_bank_pkg::*;
#(
  parameter int NWIN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_ctl,
  input  logic [NWIN-1:0]   wr_prot,
  input  logic              vsync,
  input  logic              any_pend,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              arm,
  output logic [NWIN-1:0]   protect,
  output logic              stg_disp,
  output logic              act_disp,
  output logic              pend_glob,
  output logic              glob_commit,
  output logic [DATA_W-1:0] rd_stg,
  output logic [DATA_W-1:0] rd_act
);
  logic ctrl_wr, prot_wr;

  assign ctrl_wr     = wr_en && (wr_addr == CTRL_A);
  assign prot_wr     = wr_en && (wr_addr == PROT_A);
  assign arm         = ctrl_wr && wr_ctl[1];
  assign glob_commit = vsync && pend_glob;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_disp  <= 1'b0;
      act_disp  <= 1'b0;
      pend_glob <= 1'b0;
      protect   <= '0;
    end else begin
      if (ctrl_wr) stg_disp <= wr_ctl[0];
      if (prot_wr) protect <= wr_prot;
      if (glob_commit) act_disp <= stg_disp;
      pend_glob <= arm | (pend_glob & ~glob_commit);
    end
  end

  always_comb begin
    rd_stg = '0;
    rd_act = '0;
    if (rd_addr == CTRL_A) begin
      rd_stg[0] = stg_disp;
      rd_stg[1] = any_pend;
      rd_act[0] = act_disp;
    end else if (rd_addr == PROT_A) begin
      rd_stg[NWIN-1:0] = protect;
      rd_act[NWIN-1:0] = protect;
    end
  end
endmodule

// File: rtl/shadow_win_slot.sv
module shadow_win_slot
  import shadow_bank_pkg::*;
#(
  parameter int IDX     = 0,
  parameter int BASE_W  = 32,
  parameter int COORD_W = 12,
  localparam int XY_W   = 2 * COORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              arm,
  input  logic              vsync,
  input  logic              protect,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              stg_en,
  output logic [BASE_W-1:0] stg_base,
  output logic [XY_W-1:0]   stg_tl,
  output logic [XY_W-1:0]   stg_br,
  output logic              act_en,
  output logic [BASE_W-1:0] act_base,
  output logic [XY_W-1:0]   act_tl,
  output logic [XY_W-1:0]   act_br,
  output logic              pending,
  output logic              commit,
  output logic [DATA_W-1:0] rd_stg,
  output logic [DATA_W-1:0] rd_act
);
  function automatic logic [XY_W-1:0] unpack_xy(input logic [DATA_W-1:0] d);
    return {d[Y_LSB +: COORD_W], d[0 +: COORD_W]};
  endfunction

  function automatic logic [DATA_W-1:0] pack_xy(input logic [XY_W-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[0 +: COORD_W]     = v[0 +: COORD_W];
    r[Y_LSB +: COORD_W] = v[COORD_W +: COORD_W];
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] view(input logic [ADDR_W-1:0] a, input logic en,
                                             input logic [BASE_W-1:0] b,
                                             input logic [XY_W-1:0] tl,
                                             input logic [XY_W-1:0] br);
    logic [DATA_W-1:0] r;
    r = '0;
    if (a == win_addr(IDX, F_ENA))       r[0] = en;
    else if (a == win_addr(IDX, F_BASE)) r[BASE_W-1:0] = b;
    else if (a == win_addr(IDX, F_TL))   r = pack_xy(tl);
    else if (a == win_addr(IDX, F_BR))   r = pack_xy(br);
    return r;
  endfunction

  assign commit = vsync && pending && !protect;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_en   <= 1'b0;
      stg_base <= '0;
      stg_tl   <= '0;
      stg_br   <= '0;
      act_en   <= 1'b0;
      act_base <= '0;
      act_tl   <= '0;
      act_br   <= '0;
      pending  <= 1'b0;
    end else begin
      if (wr_en) begin
        if (wr_addr == win_addr(IDX, F_ENA))  stg_en   <= wr_data[0];
        if (wr_addr == win_addr(IDX, F_BASE)) stg_base <= wr_data[BASE_W-1:0];
        if (wr_addr == win_addr(IDX, F_TL))   stg_tl   <= unpack_xy(wr_data);
        if (wr_addr == win_addr(IDX, F_BR))   stg_br   <= unpack_xy(wr_data);
      end
      if (commit) begin
        act_en   <= stg_en;
        act_base <= stg_base;
        act_tl   <= stg_tl;
        act_br   <= stg_br;
      end
      pending <= arm | (pending & ~commit);
    end
  end

  assign rd_stg = view(rd_addr, stg_en, stg_base, stg_tl, stg_br);
  assign rd_act = view(rd_addr, act_en, act_base, act_tl, act_br);
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
  import shadow_bank_pkg::*;
#(
  parameter int NWIN    = 2,
  parameter int BASE_W  = 32,
  parameter int COORD_W = 12,
  localparam int XY_W   = 2 * COORD_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   vsync,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [DATA_W-1:0]      rd_data,
  output logic [DATA_W-1:0]      act_rd_data,
  output logic                   act_disp_on,
  output logic [NWIN-1:0]        act_win_en,
  output logic [NWIN*BASE_W-1:0] act_win_base,
  output logic [NWIN*XY_W-1:0]   act_win_tl,
  output logic [NWIN*XY_W-1:0]   act_win_br
);
  logic                   arm;
  logic [NWIN-1:0]        protect;
  logic [NWIN-1:0]        pend_win;
  logic [NWIN-1:0]        win_commit;
  logic                   pend_glob;
  logic                   glob_commit;
  logic                   any_pend;
  logic                   stg_disp;
  logic [NWIN-1:0]        stg_win_en;
  logic [NWIN*BASE_W-1:0] stg_win_base;
  logic [NWIN*XY_W-1:0]   stg_win_tl;
  logic [NWIN*XY_W-1:0]   stg_win_br;
  logic [DATA_W-1:0]      glob_rd_stg, glob_rd_act;
  logic [DATA_W-1:0]      win_rd_stg [NWIN];
  logic [DATA_W-1:0]      win_rd_act [NWIN];

  assign any_pend = pend_glob | (|pend_win);

  shadow_glob_slot #(.NWIN(NWIN)) u_glob (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_ctl      (wr_data[1:0]),
    .wr_prot     (wr_data[NWIN-1:0]),
    .vsync       (vsync),
    .any_pend    (any_pend),
    .rd_addr     (rd_addr),
    .arm         (arm),
    .protect     (protect),
    .stg_disp    (stg_disp),
    .act_disp    (act_disp_on),
    .pend_glob   (pend_glob),
    .glob_commit (glob_commit),
    .rd_stg      (glob_rd_stg),
    .rd_act      (glob_rd_act)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    shadow_win_slot #(.IDX(w), .BASE_W(BASE_W), .COORD_W(COORD_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .arm      (arm),
      .vsync    (vsync),
      .protect  (protect[w]),
      .rd_addr  (rd_addr),
      .stg_en   (stg_win_en[w]),
      .stg_base (stg_win_base[w*BASE_W +: BASE_W]),
      .stg_tl   (stg_win_tl[w*XY_W +: XY_W]),
      .stg_br   (stg_win_br[w*XY_W +: XY_W]),
      .act_en   (act_win_en[w]),
      .act_base (act_win_base[w*BASE_W +: BASE_W]),
      .act_tl   (act_win_tl[w*XY_W +: XY_W]),
      .act_br   (act_win_br[w*XY_W +: XY_W]),
      .pending  (pend_win[w]),
      .commit   (win_commit[w]),
      .rd_stg   (win_rd_stg[w]),
      .rd_act   (win_rd_act[w])
    );
  end

  always_comb begin
    rd_data     = glob_rd_stg;
    act_rd_data = glob_rd_act;
    for (int w = 0; w < NWIN; w++) begin
      rd_data     = rd_data | win_rd_stg[w];
      act_rd_data = act_rd_data | win_rd_act[w];
    end
  end
endmodule

// File: rtl/shadow_bank_chk.sv
module shadow_bank_chk #(
  parameter int NWIN    = 2,
  parameter int BASE_W  = 32,
  parameter int COORD_W = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   vsync,
  input logic                   arm,
  input logic [NWIN-1:0]        protect,
  input logic [NWIN-1:0]        pend_win,
  input logic [NWIN-1:0]        win_commit,
  input logic                   pend_glob,
  input logic                   stg_disp,
  input logic [NWIN*BASE_W-1:0] stg_win_base,
  input logic                   act_disp_on,
  input logic [NWIN-1:0]        act_win_en,
  input logic [NWIN*BASE_W-1:0] act_win_base
);
  // R2
  no_vsync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> $stable(act_win_base) && $stable(act_win_en) && $stable(act_disp_on));

  // R4
  idle_vsync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && pend_win == '0 && !pend_glob) |=>
      $stable(act_win_base) && $stable(act_win_en) && $stable(act_disp_on));

  // R3
  disp_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && pend_glob) |=> act_disp_on == $past(stg_disp));

  for (genvar w = 0; w < NWIN; w++) begin : g_chk
    // R5
    protect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && protect[w]) |=> $stable(act_win_base[w*BASE_W +: BASE_W]) && $stable(act_win_en[w]));

    // R5
    protect_keep_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && protect[w] && pend_win[w]) |=> pend_win[w]);

    // R3
    base_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_commit[w] |=> act_win_base[w*BASE_W +: BASE_W] == $past(stg_win_base[w*BASE_W +: BASE_W]));

    // R7
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_commit[w] && !arm) |=> !pend_win[w]);
  end
endmodule

bind shadow_bank shadow_bank_chk #(.NWIN(NWIN), .BASE_W(BASE_W), .COORD_W(COORD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .vsync        (vsync),
  .arm          (arm),
  .protect      (protect),
  .pend_win     (pend_win),
  .win_commit   (win_commit),
  .pend_glob    (pend_glob),
  .stg_disp     (stg_disp),
  .stg_win_base (stg_win_base),
  .act_disp_on  (act_disp_on),
  .act_win_en   (act_win_en),
  .act_win_base (act_win_base)
);

// File: tb/shadow_bank_tb.sv
`timescale 1ns/1ps
module shadow_bank_tb;
  localparam int NW = 2;
  localparam int BW = 32;
  localparam int CW = 12;
  localparam int XW = 2 * CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vsync = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [5:0] rd_addr = '0;
  logic [31:0] rd_data, act_rd_data;
  logic act_disp_on;
  logic [NW-1:0] act_win_en;
  logic [NW*BW-1:0] act_win_base;
  logic [NW*XW-1:0] act_win_tl, act_win_br;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  shadow_bank #(.NWIN(NW), .BASE_W(BW), .COORD_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .act_rd_data(act_rd_data),
    .act_disp_on(act_disp_on), .act_win_en(act_win_en), .act_win_base(act_win_base),
    .act_win_tl(act_win_tl), .act_win_br(act_win_br)
  );

  // Behavioural reference model: staged/active sets as plain arrays.
  bit m_sdisp, m_adisp, m_pglob;
  bit [NW-1:0] m_prot;
  bit m_sen[NW], m_aen[NW], m_pend[NW];
  bit [31:0] m_sbase[NW], m_abase[NW], m_stl[NW], m_atl[NW], m_sbr[NW], m_abr[NW];

  function automatic bit [31:0] xy_field(input bit [31:0] d);
    return d & 32'h0FFF_0FFF;
  endfunction

  function automatic bit [XW-1:0] xy_port(input bit [31:0] d);
    return {d[27:16], d[11:0]};
  endfunction

  function automatic bit [31:0] m_read(input bit [5:0] a, input bit act);
    int w, off;
    bit any;
    any = m_pglob;
    for (int i = 0; i < NW; i++) any |= m_pend[i];
    if (a == 0) return act ? {31'd0, m_adisp} : {30'd0, any, m_sdisp};
    if (a == 1) return {30'd0, m_prot};
    if (a < 8) return 0;
    w = (a - 8) / 8;
    off = (a - 8) % 8;
    if (w >= NW || off > 3) return 0;
    case (off)
      0: return act ? {31'd0, m_aen[w]} : {31'd0, m_sen[w]};
      1: return act ? m_abase[w] : m_sbase[w];
      2: return act ? m_atl[w] : m_stl[w];
      default: return act ? m_abr[w] : m_sbr[w];
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sdisp = 0; m_adisp = 0; m_pglob = 0; m_prot = 0;
      for (int i = 0; i < NW; i++) begin
        m_sen[i] = 0; m_aen[i] = 0; m_pend[i] = 0;
        m_sbase[i] = 0; m_abase[i] = 0; m_stl[i] = 0; m_atl[i] = 0; m_sbr[i] = 0; m_abr[i] = 0;
      end
    end else begin
      if (vsync) begin
        if (m_pglob) begin m_adisp = m_sdisp; m_pglob = 0; end
        for (int i = 0; i < NW; i++)
          if (m_pend[i] && !m_prot[i]) begin
            m_aen[i] = m_sen[i]; m_abase[i] = m_sbase[i];
            m_atl[i] = m_stl[i]; m_abr[i] = m_sbr[i]; m_pend[i] = 0;
          end
      end
      if (wr_en) begin
        if (wr_addr == 0) begin
          m_sdisp = wr_data[0];
          if (wr_data[1]) begin
            m_pglob = 1;
            for (int i = 0; i < NW; i++) m_pend[i] = 1;
          end
        end else if (wr_addr == 1) begin
          m_prot = wr_data[NW-1:0];
        end else begin
          for (int i = 0; i < NW; i++) begin
            if (wr_addr == 6'(8 + 8*i)) m_sen[i] = wr_data[0];
            if (wr_addr == 6'(9 + 8*i)) m_sbase[i] = wr_data;
            if (wr_addr == 6'(10 + 8*i)) m_stl[i] = xy_field(wr_data);
            if (wr_addr == 6'(11 + 8*i)) m_sbr[i] = xy_field(wr_data);
          end
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Cycle compare against the model (R2 R3 R5 ordering of active outputs).
  always @(negedge clk) begin
    if (rst_n) begin
      bit [NW-1:0] e_en;
      bit [NW*BW-1:0] e_base;
      bit [NW*XW-1:0] e_tl, e_br;
      for (int i = 0; i < NW; i++) begin
        e_en[i] = m_aen[i];
        e_base[i*BW +: BW] = m_abase[i];
        e_tl[i*XW +: XW] = xy_port(m_atl[i]);
        e_br[i*XW +: XW] = xy_port(m_abr[i]);
      end
      chk("R3 model act_win_en", 32'(act_win_en), 32'(e_en));
      chk("R3 model act_disp_on", 32'(act_disp_on), 32'(m_adisp));
      chk("R3 model base0", act_win_base[31:0], e_base[31:0]);
      chk("R3 model base1", act_win_base[63:32], e_base[63:32]);
      chk("R9 model tl", 32'(act_win_tl[XW-1:0]) ^ 32'(act_win_tl[2*XW-1:XW]),
          32'(e_tl[XW-1:0]) ^ 32'(e_tl[2*XW-1:XW]));
      chk("R9 model br", 32'(act_win_br[XW-1:0]) ^ 32'(act_win_br[2*XW-1:XW]),
          32'(e_br[XW-1:0]) ^ 32'(e_br[2*XW-1:XW]));
      chk("R2 model rd_data", rd_data, m_read(rd_addr, 1'b0));
      chk("R2 model act_rd_data", act_rd_data, m_read(rd_addr, 1'b1));
    end
  end

  task automatic op(input bit we, input bit [5:0] a, input bit [31:0] d, input bit vs);
    @(posedge clk); #1;
    wr_en = we; wr_addr = a; wr_data = d; vsync = vs;
    @(posedge clk); #1;
    wr_en = 0; wr_addr = 0; wr_data = 0; vsync = 0;
  endtask

  task automatic wr(input bit [5:0] a, input bit [31:0] d);
    op(1'b1, a, d, 1'b0);
  endtask

  task automatic vs();
    op(1'b0, 6'd0, 32'd0, 1'b1);
  endtask

  task automatic peek(input bit [5:0] a, output logic [31:0] stg, output logic [31:0] act);
    @(negedge clk); #1;
    rd_addr = a;
    #1;
    stg = rd_data;
    act = act_rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] s, a;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    peek(6'd0, s, a); chk("R1 ctrl staged", s, 32'h0);
    peek(6'd9, s, a); chk("R1 win0 base staged", s, 32'h0);
    chk("R1 act_win_en", 32'(act_win_en), 32'h0);

    // R2: staged write, active untouched
    wr(6'd8, 32'h1);
    wr(6'd9, 32'h0000_A000);
    wr(6'd10, 32'h0014_000A);
    wr(6'd11, 32'h0050_0040);
    peek(6'd9, s, a);
    chk("R2 win0 base staged", s, 32'h0000_A000);
    chk("R2 win0 base active", a, 32'h0);
    peek(6'd10, s, a);
    chk("R9 win0 tl staged", s, 32'h0014_000A);

    // R3/R7: arm then vsync
    wr(6'd0, 32'h3);
    peek(6'd0, s, a); chk("R7 pending flag set", s, 32'h3);
    vs();
    peek(6'd9, s, a); chk("R3 win0 base active", a, 32'h0000_A000);
    chk("R3 disp active", 32'(act_disp_on), 32'h1);
    chk("R9 win0 tl active port", 32'(act_win_tl[XW-1:0]), 32'h01400A);
    peek(6'd0, s, a); chk("R7 pending self-clear", s, 32'h1);

    // R4: vsync with nothing pending
    wr(6'd9, 32'h0000_B000);
    vs();
    peek(6'd9, s, a); chk("R4 idle vsync holds", a, 32'h0000_A000);

    // R5: protect window 1
    wr(6'd1, 32'h2);
    peek(6'd1, s, a); chk("R9 protect readback", s, 32'h2);
    wr(6'd17, 32'h0000_C000);
    wr(6'd16, 32'h1);
    wr(6'd0, 32'h3);
    vs();
    peek(6'd9, s, a); chk("R5 unprotected win0 moves", a, 32'h0000_B000);
    peek(6'd17, s, a); chk("R5 protected win1 held", a, 32'h0);
    chk("R5 win1 enable held", 32'(act_win_en[1]), 32'h0);
    peek(6'd0, s, a); chk("R7 still pending", s, 32'h3);

    // R6: release protect
    wr(6'd1, 32'h0);
    peek(6'd17, s, a); chk("R6 no move before vsync", a, 32'h0);
    vs();
    peek(6'd17, s, a); chk("R6 win1 base after release", a, 32'h0000_C000);
    peek(6'd0, s, a); chk("R7 all transferred", s, 32'h1);

    // R8: disable waits for vsync
    wr(6'd8, 32'h0);
    wr(6'd0, 32'h3);
    chk("R8 enable held before vsync", 32'(act_win_en[0]), 32'h1);
    vs();
    @(negedge clk);
    chk("R8 enable dropped at vsync", 32'(act_win_en[0]), 32'h0);

    // R10: arm in same cycle as vsync
    wr(6'd17, 32'h0000_D000);
    op(1'b1, 6'd0, 32'h3, 1'b1);
    peek(6'd17, s, a); chk("R10 same-cycle arm not applied", a, 32'h0000_C000);
    vs();
    peek(6'd17, s, a); chk("R10 applied next vsync", a, 32'h0000_D000);

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule